// File: doc/BRIEF.md
# I2S to Simultaneous-Data DAC Bridge

This block takes a standard I2S stereo stream (bit clock, word select and serial data) and re-serializes it for a dual-channel multibit current-output DAC. That DAC expects a slow serial clock, one data line per channel shifting in lockstep, and a latch strobe that moves both words into the converter together. The bridge runs entirely in the I2S bit-clock domain. It keeps the top 16 bits of every 32-bit channel slot. It divides the bit clock by four to form the DAC clock, so the 16 DAC clock periods in each 64-bit stereo frame all carry sample bits.

The left word of a frame is complete long before the right word of the same frame. The bridge therefore pairs each left word with the right word of the previous frame, so the right channel runs one sample period late. The pair starts shifting as soon as the left word's last bit has been sampled. The latch strobe is timed so that each of its edges falls halfway between two DAC clock edges. The frame phase is re-derived from every falling edge of word select.

Timing terms used below: edge E is a rising bit-clock edge at which `ws` is sampled low after being sampled high at the previous edge. Slot s (0..63) is the `sdin` bit sampled at the (s+1)-th rising edge after E. Output interval n (0..63) is the bit-clock period that follows the n-th rising edge after E; interval 0 starts at E. The next E ends interval 63.

Top module: `i2s_simul_dac_bridge`

## Requirements
- R1: `ws` low selects the left channel and high selects the right. The left word is slots 0..15 and the right word is slots 32..47, most significant bit first, all sampled on the rising edge of `bclk`.
- R2: `sclk_out` is high in intervals with n mod 4 equal to 2 or 3 and low in the others. This gives one DAC clock period per four bit clocks and 16 periods per frame.
- R3: `data_l` and `data_r` change only at the start of intervals with n mod 4 = 0, where `sclk_out` falls. In intervals 16+4b .. 19+4b (taken mod 64, b = 0..15) they carry bit 15-b of their words. No interval is left idle.
- R4: The word pair that starts in interval 16 of frame F holds the left word of frame F and the right word of frame F-1. A word not received since reset is zero.
- R5: `latch_en` is high in intervals 15 and 16 only. It rises while `sclk_out` is high and falls while `sclk_out` is low, so it never changes on the same edge as `sclk_out`.
- R6: Slots 16..31 and 48..63 (the low half of each 32-bit slot, e.g. the extra bits of 24-bit data) have no effect on any output.
- R7: While `rst` is sampled high, all four outputs are zero from the next edge on, and the captured words are cleared. After reset the outputs stay zero until the first edge E.
- R8: Every edge E restarts the interval count at 0, whatever phase the count had before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | I2S bit clock; clocks the whole block |
| rst | input | 1 | Synchronous active-high reset |
| ws | input | 1 | I2S word select (0 = left, 1 = right) |
| sdin | input | 1 | I2S serial data |
| sclk_out | output | 1 | DAC bit clock, `bclk` divided by 4 |
| data_l | output | 1 | Left channel serial data to the DAC |
| data_r | output | 1 | Right channel serial data to the DAC |
| latch_en | output | 1 | Latch strobe that moves both words into the DAC |

## Verification
A wrong frame phase appears first on `sclk_out`: the output clock is offset within the first four bit clocks after a word-select fall, and `latch_en` lands outside intervals 15 and 16 in the same frame. A bad capture shift register or a wrong channel pairing gives no timing symptom. It appears only as wrong bits on `data_l` or `data_r` during the word that starts 16 intervals after the frame boundary, so each output bit is compared with a model in every interval. A reset that leaks old state appears as nonzero right-channel data in the first word after resynchronization.

// File: rtl/i2s_simul_pkg.sv
package i2s_simul_pkg;
  // Lane index for the two DAC data lines.
  typedef enum logic {
    LANE_LEFT  = 1'b0,
    LANE_RIGHT = 1'b1
  } lane_e;

  localparam int NUM_LANES = 2;
endpackage

// File: rtl/i2s_simul_framer.sv
// Tracks the stereo frame position from word select and captures the
// upper WORD_BITS of each channel slot.
module i2s_simul_framer #(
  parameter  int SLOT_BITS   = 32,
  parameter  int WORD_BITS   = 16,
  localparam int FRAME_SLOTS = 2 * SLOT_BITS,
  localparam int FW          = $clog2(FRAME_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ws,
  input  logic                 sd,
  output logic                 run,
  output logic [FW-1:0]        slot_now,
  output logic [WORD_BITS-1:0] left_word,
  output logic [WORD_BITS-1:0] right_word
);
  localparam logic [FW-1:0] LAST_SLOT = FW'(FRAME_SLOTS - 1);
  localparam logic [FW-1:0] L_LAST    = FW'(WORD_BITS - 1);
  localparam logic [FW-1:0] R_FIRST   = FW'(SLOT_BITS);
  localparam logic [FW-1:0] R_LAST    = FW'(SLOT_BITS + WORD_BITS - 1);

  logic                 ws_q;
  logic                 ws_fall;
  logic                 synced_q;
  logic [FW-1:0]        slot_q;
  logic [WORD_BITS-2:0] cap_l;
  logic [WORD_BITS-1:0] cap_r;

  // Word select history is kept through reset so a fall right after
  // release is still seen.
  always_ff @(posedge clk) ws_q <= ws;

  assign ws_fall = ws_q & ~ws;

  // The bit sampled together with a word-select fall is the last slot.
  always_comb begin
    slot_now = ws_fall ? LAST_SLOT : slot_q;
    run      = synced_q | ws_fall;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q   <= '0;
      synced_q <= 1'b0;
      cap_l    <= '0;
      cap_r    <= '0;
    end else begin
      slot_q <= slot_now + 1'b1;
      if (ws_fall) synced_q <= 1'b1;
      if (run && slot_now <= L_LAST)
        cap_l <= {cap_l[WORD_BITS-3:0], sd};
      if (run && slot_now >= R_FIRST && slot_now <= R_LAST)
        cap_r <= {cap_r[WORD_BITS-2:0], sd};
    end
  end

  // Left word including the bit on the line right now.
  assign left_word  = {cap_l, sd};
  assign right_word = cap_r;
endmodule

// File: rtl/i2s_simul_lane.sv
// One DAC data line: parallel load, shift out MSB first.
module i2s_simul_lane #(
  parameter int WORD_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic                 shift,
  input  logic [WORD_BITS-1:0] word,
  output logic                 ser_out
);
  logic [WORD_BITS-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)        sr <= '0;
    else if (load)  sr <= word;
    else if (shift) sr <= {sr[WORD_BITS-2:0], 1'b0};
  end

  assign ser_out = sr[WORD_BITS-1];
endmodule

// File: rtl/i2s_simul_strobe.sv
// Registered DAC clock and latch strobe derived from the next interval.
module i2s_simul_strobe #(
  parameter  int FW        = 6,
  parameter  int CLK_DIV   = 4,
  parameter  int LOAD_SLOT = 16,
  localparam int DW        = $clog2(CLK_DIV)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [FW-1:0] next_slot,
  output logic          sclk,
  output logic          le
);
  // Strobe covers the last quarter of the final bit and the first
  // quarter of the new word: both edges sit between DAC clock edges.
  localparam logic [FW-1:0] LE_ON  = FW'(LOAD_SLOT - 1);
  localparam logic [FW-1:0] LE_END = FW'(LOAD_SLOT);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      sclk <= 1'b0;
      le   <= 1'b0;
    end else begin
      sclk <= next_slot[DW-1];
      le   <= (next_slot == LE_ON) || (next_slot == LE_END);
    end
  end
endmodule

// File: rtl/i2s_simul_dac_bridge.sv
// I2S in, simultaneous left/right serial data with latch strobe out.
module i2s_simul_dac_bridge
  import i2s_simul_pkg::*;
#(
  parameter int SLOT_BITS = 32,
  parameter int WORD_BITS = 16,
  parameter int CLK_DIV   = 4
) (
  input  logic bclk,
  input  logic rst,
  input  logic ws,
  input  logic sdin,
  output logic sclk_out,
  output logic data_l,
  output logic data_r,
  output logic latch_en
);
  localparam int FRAME_SLOTS = 2 * SLOT_BITS;
  localparam int FW          = $clog2(FRAME_SLOTS);
  localparam int DW          = $clog2(CLK_DIV);
  // A new word pair starts right after the left word is complete.
  localparam int LOAD_SLOT   = WORD_BITS;
  localparam logic [FW-1:0] LOAD_PREV = FW'(LOAD_SLOT - 1);

  logic                                  run;
  logic [FW-1:0]                         slot_now;
  logic [FW-1:0]                         next_slot;
  logic                                  load;
  logic                                  shift;
  logic [NUM_LANES-1:0][WORD_BITS-1:0]   words;
  logic [NUM_LANES-1:0]                  ser;

  i2s_simul_framer #(
    .SLOT_BITS (SLOT_BITS),
    .WORD_BITS (WORD_BITS)
  ) u_framer (
    .clk        (bclk),
    .rst        (rst),
    .ws         (ws),
    .sd         (sdin),
    .run        (run),
    .slot_now   (slot_now),
    .left_word  (words[LANE_LEFT]),
    .right_word (words[LANE_RIGHT])
  );

  assign next_slot = slot_now + 1'b1;
  assign load      = run && (slot_now == LOAD_PREV);
  assign shift     = run && (next_slot[DW-1:0] == '0) && !load;

  for (genvar ch = 0; ch < NUM_LANES; ch++) begin : g_lane
    i2s_simul_lane #(
      .WORD_BITS (WORD_BITS)
    ) u_lane (
      .clk     (bclk),
      .rst     (rst),
      .load    (load),
      .shift   (shift),
      .word    (words[ch]),
      .ser_out (ser[ch])
    );
  end

  i2s_simul_strobe #(
    .FW        (FW),
    .CLK_DIV   (CLK_DIV),
    .LOAD_SLOT (LOAD_SLOT)
  ) u_strobe (
    .clk       (bclk),
    .rst       (rst),
    .run       (run),
    .next_slot (next_slot),
    .sclk      (sclk_out),
    .le        (latch_en)
  );

  assign data_l = ser[LANE_LEFT];
  assign data_r = ser[LANE_RIGHT];
endmodule

// File: rtl/i2s_simul_dac_bridge_sva.sv
// Port-level properties of the bridge, attached by bind.
module i2s_simul_dac_bridge_sva (
  input logic clk,
  input logic rst,
  input logic ws,
  input logic sclk_out,
  input logic data_l,
  input logic data_r,
  input logic latch_en
);
  AST_SYNC_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
    ($past(ws) && !ws) |=> !sclk_out); // R8

  AST_CLK_HIGH_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk_out) |=> (sclk_out || ($past(ws, 2) && !$past(ws)))); // R2

  AST_CLK_LOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk_out) |=> !sclk_out); // R2

  AST_LEFT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    $changed(data_l) |-> ($fell(sclk_out) || ($past(ws, 2) && !$past(ws)))); // R3

  AST_RIGHT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    $changed(data_r) |-> ($fell(sclk_out) || ($past(ws, 2) && !$past(ws)))); // R3

  AST_LE_MIDPOINT: assert property (@(posedge clk) disable iff (rst)
    $changed(latch_en) |-> $stable(sclk_out)); // R5

  AST_LE_IN_HIGH: assert property (@(posedge clk) disable iff (rst)
    $rose(latch_en) |-> sclk_out); // R5

  AST_LE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(latch_en) |=> latch_en ##1 !latch_en); // R5

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!sclk_out && !data_l && !data_r && !latch_en)); // R7
endmodule

bind i2s_simul_dac_bridge i2s_simul_dac_bridge_sva u_sva (
  .clk      (bclk),
  .rst      (rst),
  .ws       (ws),
  .sclk_out (sclk_out),
  .data_l   (data_l),
  .data_r   (data_r),
  .latch_en (latch_en)
);

// File: tb/i2s_simul_dac_bridge_test.sv
module i2s_simul_dac_bridge_test;
  localparam int CLK_PERIOD = 10;
  localparam int NF         = 24;

  logic bclk = 1'b0;
  logic rst  = 1'b1;
  logic ws   = 1'b1;
  logic sdin = 1'b0;
  logic sclk_out, data_l, data_r, latch_en;

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0] lw [NF];
  logic [31:0] rw [NF];

  i2s_simul_dac_bridge uut (
    .bclk     (bclk),
    .rst      (rst),
    .ws       (ws),
    .sdin     (sdin),
    .sclk_out (sclk_out),
    .data_l   (data_l),
    .data_r   (data_r),
    .latch_en (latch_en)
  );

  always #(CLK_PERIOD/2) bclk = ~bclk;

  task automatic chk(string req, int m, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s interval %0d: got %0b expected %0b", req, m, act, exp);
    end
  endtask

  // Expected output from the requirements. sel: 0 clk, 1 left, 2 right, 3 latch.
  function automatic logic exp_out(int m, int sel);
    int n  = m % 64;
    int fr = m / 64;
    int lf = (n >= 16) ? fr : fr - 1;
    int b  = (n >= 16) ? (n - 16) / 4 : (n + 48) / 4;
    case (sel)
      0: return ((n / 2) % 2) == 1;                     // R2
      3: return (n == 15) || (n == 16);                 // R5
      1: return (lf < 0) ? 1'b0 : lw[lf][31-b];         // R1 R3 R6
      default: return (lf < 1) ? 1'b0 : rw[lf-1][31-b]; // R4
    endcase
  endfunction

  task automatic check_all(int m, string clk_tag);
    chk(clk_tag, m, sclk_out, exp_out(m, 0));
    chk("R5 latch_en", m, latch_en, exp_out(m, 3));
    chk("R1/R3/R6 data_l", m, data_l, exp_out(m, 1));
    chk("R1/R4/R6 data_r", m, data_r, exp_out(m, 2));
  endtask

  task automatic check_idle(string req);
    chk({req, " sclk_out"}, -1, sclk_out, 1'b0);
    chk({req, " latch_en"}, -1, latch_en, 1'b0);
    chk({req, " data_l"},   -1, data_l,   1'b0);
    chk({req, " data_r"},   -1, data_r,   1'b0);
  endtask

  task automatic drive_slot(int g);
    if (g < 0) begin
      ws   = 1'b0;
      sdin = 1'b0;
    end else begin
      int fr = g / 64;
      int s  = g % 64;
      ws   = (s >= 31) && (s <= 62);
      sdin = (s < 32) ? lw[fr][31-s] : rw[fr][63-s];
    end
  endtask

  task automatic idle(int cycles, string req);
    for (int i = 0; i < cycles; i++) begin
      @(negedge bclk);
      check_idle(req);
      ws   = 1'b1;
      sdin = 1'($urandom);
    end
  endtask

  task automatic run_frames(string clk_tag);
    for (int g = -1; g < 64 * NF; g++) begin
      @(negedge bclk);
      if (g >= 0) check_all(g, clk_tag);
      else check_idle("R7 pre-sync");
      drive_slot(g);
    end
    @(negedge bclk);
    check_all(64 * NF, clk_tag);
  endtask

  initial begin
    void'($urandom(32'd7919));
    for (int f = 0; f < NF; f++) begin
      lw[f] = $urandom;
      rw[f] = $urandom;
    end
    // Directed corners: lone MSB, low-half junk only (R6), alternating bits.
    lw[0] = 32'h8000_FFFF; rw[0] = 32'h0001_FFFF;
    lw[1] = 32'h0000_FFFF; rw[1] = 32'hFFFF_0000;
    lw[2] = 32'hAAAA_5555; rw[2] = 32'h5555_AAAA;
    lw[3] = 32'hFFFF_FFFF; rw[3] = 32'h0000_FFFF;

    // Reset state (R7).
    repeat (4) begin
      @(negedge bclk);
      check_idle("R7 in reset");
    end
    rst = 1'b0;
    idle(3, "R7 after reset");
    run_frames("R2 sclk_out");

    // Mid-stream reset, then resynchronize at a different free-run phase (R8).
    rst = 1'b1;
    ws  = 1'b1;
    repeat (4) begin
      @(negedge bclk);
      check_idle("R7 mid-stream reset");
      sdin = 1'($urandom);
    end
    rst = 1'b0;
    for (int f = 0; f < NF; f++) begin
      lw[f] = $urandom;
      rw[f] = $urandom;
    end
    lw[0] = 32'h7FFF_0000; rw[0] = 32'hC003_8001;
    idle(5, "R7 before resync");
    run_frames("R2/R8 sclk_out");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule